// File: doc/BRIEF.md
# Media Engine Reset Sequencer

This block carries out a safe reset of a selected set of media engines (decode engines and enhancement engines) that share scaler units. A reset is requested by a one-cycle start pulse together with a decode-engine mask and an enhancement-engine mask. The sequencer first places every affected engine that can reach a scaler under a forced lock and waits for each lock acknowledge. It then reads the usage indication of each acknowledged engine and widens the reset with the reset bit of any scaler that engine holds. It drives the combined reset-domain vector as a fixed-length pulse, drops all forced locks, and reports completion.

A full-chip request bypasses the lock handshake: no forced lock is raised and only the full-chip domain bit is pulsed. If an acknowledge does not arrive within a programmable number of wait cycles, the sequencer flags a timeout and goes on without that engine's scaler bit. Engine vectors place decode engine i at index i and enhancement engine j at index NUM_DEC+j.

Top module: `media_rst_seq`

## Requirements
- R1: A start pulse seen while busy_o is low is accepted and busy_o is high from the next cycle until the cycle after done_o; a start pulse while busy_o is high has no effect on the sequence in progress (its pulse value, length and timing).
- R2: After an accepted non-full-chip start, force_lock_o is set for every requested enhancement engine and for every requested decode engine whose bit is set in DEC_SCL_ACCESS (default 4'b0101), and for no other engine; it stays set through the last reset pulse cycle.
- R3: The reset pulse begins in the cycle after the first wait cycle in which every forced-locked engine has shown its acknowledge (acknowledges are remembered once seen); with all acknowledges present at once there is exactly one wait cycle.
- R4: An acknowledged engine whose usage_i bit is set adds its scaler bit to the pulse: decode engine i adds bit 17 + (i>>1), enhancement engine j adds bit 17 + j.
- R5: Every requested engine has its own bit in the pulse: decode engine i at bit 5 + i, enhancement engine j at bit 13 + j, whether or not it has scaler access.
- R6: dom_reset_o is non-zero for exactly 4 consecutive cycles per sequence and holds the same value in all of them.
- R7: force_lock_o is all zero in the cycle after the last pulse cycle, and done_o is high for exactly one cycle, the second cycle after the last pulse cycle, with force_lock_o zero in that cycle and the one before.
- R8: If acknowledges are still missing after tmo_limit_i wait cycles, the pulse begins after that many wait cycles, timeout_o goes high and stays high until the next accepted start clears it, and unacknowledged engines add no scaler bit.
- R9: A full-chip start raises no forced lock and pulses only bit 0 of dom_reset_o, starting in the cycle right after the start is accepted.
- R10: Out of reset, and whenever busy_o is low, dom_reset_o, force_lock_o, done_o are zero; timeout_o is zero after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Request a reset sequence |
| dec_mask_i | input | NUM_DEC | Decode engines to reset |
| enh_mask_i | input | NUM_ENH | Enhancement engines to reset |
| full_chip_i | input | 1 | Request a full-chip reset instead |
| tmo_limit_i | input | TMO_W | Maximum wait cycles for acknowledges (0 acts as 1) |
| lock_ack_i | input | NUM_DEC+NUM_ENH | Forced-lock acknowledge per engine |
| usage_i | input | NUM_DEC+NUM_ENH | Engine holds a scaler, per engine |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | One-cycle completion strobe |
| timeout_o | output | 1 | An acknowledge was missing at the wait limit |
| force_lock_o | output | NUM_DEC+NUM_ENH | Forced-lock request per engine |
| dom_reset_o | output | DOM_W | Reset-domain pulse vector |

## Verification
The end of the acknowledge wait and the widening of the mask happen in the same cycle: the final acknowledge, the usage bits of every engine and the wait-limit expiry are all sampled at one edge. The bench provokes this by releasing the last acknowledge several cycles late with usage already high, and by letting the limit expire with one engine silent, then judges the pulse value bit by bit against the mapping, the number of wait cycles, and whether timeout_o rose. A start pulse arriving mid-sequence is also provoked and judged by an unchanged pulse.

// File: rtl/mrs_pkg.sv
package mrs_pkg;
   typedef enum logic [2:0] {
      ST_IDLE  = 3'd0,
      ST_WAIT  = 3'd1,
      ST_PULSE = 3'd2,
      ST_REL   = 3'd3,
      ST_DONE  = 3'd4
   } mrs_state_e;
endpackage

// File: rtl/mrs_dom_map.sv
// Maps engine vectors to reset-domain bits: each engine's own bit, and the
// scaler bit of each engine that currently owns a scaler.
module mrs_dom_map #(
   parameter int NUM_DEC  = 4,
   parameter int NUM_ENH  = 2,
   parameter int DOM_W    = 19,
   parameter int DEC_BASE = 5,
   parameter int ENH_BASE = 13,
   parameter int SCL_BASE = 17
) (
   input  logic [NUM_DEC+NUM_ENH-1:0] eng_i,
   input  logic [NUM_DEC+NUM_ENH-1:0] owner_i,
   output logic [DOM_W-1:0]           eng_bits_o,
   output logic [DOM_W-1:0]           scl_bits_o
);
   localparam int NE = NUM_DEC + NUM_ENH;

   logic [DOM_W-1:0] eng_c [NE];
   logic [DOM_W-1:0] scl_c [NE];

   for (genvar i = 0; i < NUM_DEC; i++) begin : g_dec
      localparam int EB = DEC_BASE + i;
      localparam int SB = SCL_BASE + (i >> 1);
      assign eng_c[i] = {DOM_W{eng_i[i]}}   & (DOM_W'(1) << EB);
      assign scl_c[i] = {DOM_W{owner_i[i]}} & (DOM_W'(1) << SB);
   end

   for (genvar j = 0; j < NUM_ENH; j++) begin : g_enh
      localparam int EB = ENH_BASE + j;
      localparam int SB = SCL_BASE + j;
      assign eng_c[NUM_DEC+j] = {DOM_W{eng_i[NUM_DEC+j]}}   & (DOM_W'(1) << EB);
      assign scl_c[NUM_DEC+j] = {DOM_W{owner_i[NUM_DEC+j]}} & (DOM_W'(1) << SB);
   end

   always_comb begin
      eng_bits_o = '0;
      scl_bits_o = '0;
      for (int k = 0; k < NE; k++) begin
         eng_bits_o = eng_bits_o | eng_c[k];
         scl_bits_o = scl_bits_o | scl_c[k];
      end
   end
endmodule

// File: rtl/mrs_ack_wait.sv
// Collects lock acknowledges during the wait phase and bounds the wait.
module mrs_ack_wait #(
   parameter int NE    = 6,
   parameter int TMO_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clear_i,
   input  logic             run_i,
   input  logic [NE-1:0]    lock_i,
   input  logic [NE-1:0]    ack_i,
   input  logic [TMO_W-1:0] limit_i,
   output logic [NE-1:0]    acked_o,
   output logic             finish_o,
   output logic             expired_o
);
   logic [NE-1:0]    acked_q;
   logic [TMO_W-1:0] cnt_q;
   logic [TMO_W-1:0] last_cnt;
   logic             all_ok;
   logic             at_limit;

   assign acked_o   = (acked_q | ack_i) & lock_i;
   assign all_ok    = (acked_o == lock_i);
   assign last_cnt  = (limit_i == '0) ? '0 : limit_i - TMO_W'(1);
   assign at_limit  = (cnt_q == last_cnt);
   assign finish_o  = run_i & (all_ok | at_limit);
   assign expired_o = run_i & ~all_ok & at_limit;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         acked_q <= '0;
         cnt_q   <= '0;
      end else if (clear_i) begin
         acked_q <= '0;
         cnt_q   <= '0;
      end else if (run_i) begin
         acked_q <= acked_o;
         cnt_q   <= cnt_q + TMO_W'(1);
      end
   end
endmodule

// File: rtl/media_rst_seq.sv
module media_rst_seq #(
   parameter int                NUM_DEC        = 4,
   parameter int                NUM_ENH        = 2,
   parameter int                DOM_W          = 19,
   parameter int                FULL_BIT       = 0,
   parameter int                DEC_BASE       = 5,
   parameter int                ENH_BASE       = 13,
   parameter int                SCL_BASE       = 17,
   parameter logic [NUM_DEC-1:0] DEC_SCL_ACCESS = 4'b0101,
   parameter int                TMO_W          = 8,
   parameter int                PULSE_LEN      = 4
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       start_i,
   input  logic [NUM_DEC-1:0]         dec_mask_i,
   input  logic [NUM_ENH-1:0]         enh_mask_i,
   input  logic                       full_chip_i,
   input  logic [TMO_W-1:0]           tmo_limit_i,
   input  logic [NUM_DEC+NUM_ENH-1:0] lock_ack_i,
   input  logic [NUM_DEC+NUM_ENH-1:0] usage_i,
   output logic                       busy_o,
   output logic                       done_o,
   output logic                       timeout_o,
   output logic [NUM_DEC+NUM_ENH-1:0] force_lock_o,
   output logic [DOM_W-1:0]           dom_reset_o
);
   import mrs_pkg::*;

   localparam int NE      = NUM_DEC + NUM_ENH;
   localparam int NUM_SCL = (((NUM_DEC - 1) >> 1) > (NUM_ENH - 1) ?
                             ((NUM_DEC - 1) >> 1) : (NUM_ENH - 1)) + 1;
   localparam int PCNT_W  = $clog2(PULSE_LEN + 1);

   if (SCL_BASE + NUM_SCL > DOM_W) begin : g_bad_scl
      $error("scaler bits exceed the reset-domain vector");
   end
   if (ENH_BASE + NUM_ENH > DOM_W || DEC_BASE + NUM_DEC > DOM_W) begin : g_bad_eng
      $error("engine bits exceed the reset-domain vector");
   end
   if (PULSE_LEN < 1 || FULL_BIT >= DOM_W) begin : g_bad_misc
      $error("pulse length or full-chip bit out of range");
   end

   mrs_state_e        state_q;
   logic [NE-1:0]     lock_q;
   logic [DOM_W-1:0]  mask_q;
   logic              tmo_q;
   logic [PCNT_W-1:0] pcnt_q;

   logic [NE-1:0]     req_vec;
   logic [NE-1:0]     lock_set;
   logic [NE-1:0]     acked;
   logic [DOM_W-1:0]  eng_bits;
   logic [DOM_W-1:0]  scl_bits;
   logic              accept;
   logic              in_wait;
   logic              wait_fin;
   logic              wait_exp;

   assign req_vec  = {enh_mask_i, dec_mask_i};
   assign lock_set = {enh_mask_i, dec_mask_i & DEC_SCL_ACCESS};
   assign accept   = start_i && (state_q == ST_IDLE);
   assign in_wait  = (state_q == ST_WAIT);

   mrs_ack_wait #(.NE(NE), .TMO_W(TMO_W)) u_wait (
      .clk      (clk),
      .rst_n    (rst_n),
      .clear_i  (accept),
      .run_i    (in_wait),
      .lock_i   (lock_q),
      .ack_i    (lock_ack_i),
      .limit_i  (tmo_limit_i),
      .acked_o  (acked),
      .finish_o (wait_fin),
      .expired_o(wait_exp)
   );

   mrs_dom_map #(
      .NUM_DEC (NUM_DEC),
      .NUM_ENH (NUM_ENH),
      .DOM_W   (DOM_W),
      .DEC_BASE(DEC_BASE),
      .ENH_BASE(ENH_BASE),
      .SCL_BASE(SCL_BASE)
   ) u_map (
      .eng_i     (req_vec),
      .owner_i   (acked & usage_i),
      .eng_bits_o(eng_bits),
      .scl_bits_o(scl_bits)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         lock_q  <= '0;
         mask_q  <= '0;
         tmo_q   <= 1'b0;
         pcnt_q  <= '0;
      end else begin
         unique case (state_q)
            ST_IDLE: begin
               if (accept) begin
                  tmo_q  <= 1'b0;
                  pcnt_q <= '0;
                  if (full_chip_i) begin
                     state_q <= ST_PULSE;
                     lock_q  <= '0;
                     mask_q  <= DOM_W'(1) << FULL_BIT;
                  end else begin
                     state_q <= ST_WAIT;
                     lock_q  <= lock_set;
                     mask_q  <= eng_bits;
                  end
               end
            end
            ST_WAIT: begin
               if (wait_fin) begin
                  mask_q  <= mask_q | scl_bits;
                  tmo_q   <= wait_exp;
                  state_q <= ST_PULSE;
               end
            end
            ST_PULSE: begin
               pcnt_q <= pcnt_q + PCNT_W'(1);
               if (pcnt_q == PCNT_W'(PULSE_LEN - 1)) begin
                  state_q <= ST_REL;
                  lock_q  <= '0;
               end
            end
            ST_REL:  state_q <= ST_DONE;
            ST_DONE: state_q <= ST_IDLE;
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   assign busy_o       = (state_q != ST_IDLE);
   assign done_o       = (state_q == ST_DONE);
   assign timeout_o    = tmo_q;
   assign force_lock_o = lock_q;
   assign dom_reset_o  = (state_q == ST_PULSE) ? mask_q : '0;
endmodule

// File: rtl/media_rst_seq_chk.sv
module media_rst_seq_chk #(
   parameter int NE        = 6,
   parameter int DOM_W     = 19,
   parameter int FULL_BIT  = 0,
   parameter int PULSE_LEN = 4
) (
   input logic             clk,
   input logic             rst_n,
   input logic             busy_o,
   input logic             done_o,
   input logic             timeout_o,
   input logic [NE-1:0]    force_lock_o,
   input logic [NE-1:0]    lock_ack_i,
   input logic [DOM_W-1:0] dom_reset_o
);
   localparam int RW = $clog2(PULSE_LEN + 1) + 1;
   logic [RW-1:0] run_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                run_q <= '0;
      else if (dom_reset_o != '0) run_q <= run_q + RW'(1);
      else                       run_q <= '0;
   end

   assert_idle_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
      !busy_o |-> (dom_reset_o == '0 && force_lock_o == '0 && !done_o));

   assert_pulse_short_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (dom_reset_o != '0) |-> (run_q < RW'(PULSE_LEN)));

   assert_pulse_full_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (dom_reset_o == '0 && $past(dom_reset_o) != '0) |-> ($past(run_q) == RW'(PULSE_LEN - 1)));

   assert_pulse_stable_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (dom_reset_o != '0 && $past(dom_reset_o) != '0) |-> $stable(dom_reset_o));

   assert_done_released_R7: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> (force_lock_o == '0 && $past(force_lock_o) == '0));

   assert_full_no_lock_R9: assert property (@(posedge clk) disable iff (!rst_n)
      dom_reset_o[FULL_BIT] |-> (force_lock_o == '0));

   assert_acked_before_pulse_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (dom_reset_o != '0 && !timeout_o) |-> ((lock_ack_i & force_lock_o) == force_lock_o));
endmodule

bind media_rst_seq media_rst_seq_chk #(
   .NE       (NUM_DEC + NUM_ENH),
   .DOM_W    (DOM_W),
   .FULL_BIT (FULL_BIT),
   .PULSE_LEN(PULSE_LEN)
) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .busy_o      (busy_o),
   .done_o      (done_o),
   .timeout_o   (timeout_o),
   .force_lock_o(force_lock_o),
   .lock_ack_i  (lock_ack_i),
   .dom_reset_o (dom_reset_o)
);

// File: tb/media_rst_seq_tb_top.sv
`timescale 1ns/1ps
module media_rst_seq_tb_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start = 1'b0;
   logic [3:0]  dec = '0;
   logic [1:0]  enh = '0;
   logic        full = 1'b0;
   logic [7:0]  limit = 8'd16;
   logic [5:0]  ack_en = '0;
   logic [5:0]  usage = '0;
   logic [5:0]  lock_ack;
   logic        busy, done, tmo;
   logic [5:0]  flock;
   logic [18:0] dom;

   always #2.5 clk = ~clk;

   assign lock_ack = flock & ack_en;

   media_rst_seq dut_i (
      .clk(clk), .rst_n(rst_n), .start_i(start), .dec_mask_i(dec),
      .enh_mask_i(enh), .full_chip_i(full), .tmo_limit_i(limit),
      .lock_ack_i(lock_ack), .usage_i(usage), .busy_o(busy), .done_o(done),
      .timeout_o(tmo), .force_lock_o(flock), .dom_reset_o(dom)
   );

   int errs = 0;
   int checks = 0;

   task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         errs++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   // expected pulse computed from the stated bit mapping
   function automatic logic [18:0] exp_dom(input logic [3:0] d, input logic [1:0] e,
                                           input logic [5:0] use_v, input logic [5:0] ackd);
      logic [18:0] v = '0;
      logic [3:0]  acc = 4'b0101;
      for (int i = 0; i < 4; i++) if (d[i]) begin
         v[5+i] = 1'b1;
         if (acc[i] && use_v[i] && ackd[i]) v[17+(i>>1)] = 1'b1;
      end
      for (int j = 0; j < 2; j++) if (e[j]) begin
         v[13+j] = 1'b1;
         if (use_v[4+j] && ackd[4+j]) v[17+j] = 1'b1;
      end
      return v;
   endfunction

   int          r_wait, r_plen, r_gap;
   logic [18:0] r_pval;
   logic [5:0]  r_lock;
   bit          r_stable, r_done, r_rel, r_tmo_first, r_tmo_done, r_busy_after, r_done_after;

   task automatic do_seq(input logic [3:0] d, input logic [1:0] e, input bit f,
                         input logic [5:0] ack_final, input int delay, input bit poke);
      logic [5:0] prev_lock = '0;
      int last_p = 0;
      r_wait = 0; r_plen = 0; r_gap = -1; r_pval = '0; r_lock = '0;
      r_stable = 1; r_done = 0; r_rel = 0; r_tmo_first = 0; r_tmo_done = 0;
      @(negedge clk);
      dec = d; enh = e; full = f; ack_en = '0; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      for (int k = 0; k < 400; k++) begin
         if (k == 0) r_tmo_first = tmo;
         r_lock |= flock;
         if (dom != '0) begin
            if (r_plen == 0) r_pval = dom;
            else if (dom != r_pval) r_stable = 0;
            r_plen++;
            last_p = k;
         end else if (r_plen == 0) r_wait++;
         if (done) begin
            r_done = 1;
            r_gap = k - last_p;
            r_rel = (flock == '0) && (prev_lock == '0);
            r_tmo_done = tmo;
            break;
         end
         prev_lock = flock;
         if (k == delay) ack_en = ack_final;
         if (poke && k == 1) begin start = 1'b1; full = ~f; dec = ~d; enh = ~e; end
         if (poke && k == 2) begin start = 1'b0; full = f; dec = d; enh = e; end
         @(negedge clk);
      end
      @(negedge clk);
      r_busy_after = busy;
      r_done_after = done;
   endtask

   task automatic common_checks(input string tag);
      chk(r_done, {tag, " R7 done seen"}, 32'(r_done), 1);
      chk(r_plen == 4, {tag, " R6 pulse length"}, r_plen, 4);
      chk(r_stable, {tag, " R6 pulse stable"}, 32'(r_stable), 1);
      chk(r_gap == 2 && r_rel, {tag, " R7 done after release"}, r_gap, 2);
      chk(!r_busy_after && !r_done_after, {tag, " R1 idle after done"}, {r_busy_after, r_done_after}, 0);
   endtask

   task automatic t_reset();
      chk(!busy && !done && !tmo && flock == '0 && dom == '0, "R10 reset state",
          {busy, done, tmo, flock, dom}, 0);
   endtask

   task automatic t_single();
      usage = 6'b000001; limit = 8'd16;
      do_seq(4'b0001, 2'b00, 0, 6'b111111, 0, 0);
      chk(r_lock == 6'b000001, "R2 lock set single", r_lock, 6'b000001);
      chk(r_wait == 1, "R3 one wait cycle", r_wait, 1);
      chk(r_pval == exp_dom(4'b0001, 2'b00, usage, 6'b111111), "R4 R5 single pulse",
          r_pval, exp_dom(4'b0001, 2'b00, usage, 6'b111111));
      common_checks("single");
   endtask

   task automatic t_no_access();
      usage = 6'b000010;
      do_seq(4'b0010, 2'b00, 0, 6'b111111, 0, 0);
      chk(r_lock == '0, "R2 no lock without access", r_lock, 0);
      chk(r_pval == 19'h00040, "R5 engine bit only", r_pval, 19'h00040);
      common_checks("noacc");
   endtask

   task automatic t_mixed();
      usage = 6'b010100;
      do_seq(4'b0100, 2'b01, 0, 6'b111111, 0, 0);
      chk(r_lock == 6'b010100, "R2 lock set mixed", r_lock, 6'b010100);
      chk(r_pval == 19'h62080, "R4 mixed scaler bits", r_pval, 19'h62080);
      common_checks("mixed");
   endtask

   task automatic t_delayed();
      usage = 6'b100000;
      do_seq(4'b0001, 2'b10, 0, 6'b100001, 3, 0);
      chk(r_wait == 4, "R3 waits for late ack", r_wait, 4);
      chk(r_pval == 19'h44020, "R4 enhancement scaler bit", r_pval, 19'h44020);
      chk(!r_tmo_done, "R8 no timeout when acked", 32'(r_tmo_done), 0);
      common_checks("delayed");
   endtask

   task automatic t_timeout();
      usage = 6'b010100; limit = 8'd5;
      do_seq(4'b0100, 2'b01, 0, 6'b000100, 0, 0);
      chk(r_wait == 5, "R8 wait bounded by limit", r_wait, 5);
      chk(r_tmo_done, "R8 timeout flagged", 32'(r_tmo_done), 1);
      chk(r_pval == 19'h42080, "R8 no bit for silent engine", r_pval, 19'h42080);
      chk(tmo, "R8 timeout held while idle", 32'(tmo), 1);
      common_checks("timeout");
      limit = 8'd16;
   endtask

   task automatic t_full();
      usage = 6'b111111;
      do_seq(4'b1111, 2'b11, 1, 6'b111111, 0, 0);
      chk(!r_tmo_first, "R8 timeout cleared by new start", 32'(r_tmo_first), 0);
      chk(r_lock == '0, "R9 no lock on full chip", r_lock, 0);
      chk(r_wait == 0, "R9 pulse starts at once", r_wait, 0);
      chk(r_pval == 19'h00001, "R9 only full-chip bit", r_pval, 1);
      common_checks("full");
   endtask

   task automatic t_busy_start();
      usage = 6'b000001;
      do_seq(4'b0001, 2'b00, 0, 6'b111111, 4, 1);
      chk(r_lock == 6'b000001, "R1 lock unchanged by busy start", r_lock, 6'b000001);
      chk(r_wait == 5, "R1 timing unchanged by busy start", r_wait, 5);
      chk(r_pval == 19'h20020, "R1 pulse unchanged by busy start", r_pval, 19'h20020);
      common_checks("busy");
   endtask

   task automatic finish_run();
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      errs++; checks++;
      $display("FAIL watchdog expired");
      finish_run();
   end

   initial begin
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_single();
      t_no_access();
      t_mixed();
      t_delayed();
      t_timeout();
      t_full();
      t_busy_start();
      finish_run();
   end
endmodule